// File: doc/BRIEF.md
# Read-Address Unlock Sequence Detector

This block sits beside the bus of a nonvolatile static memory and watches the accesses made to it. Each completed access arrives as a one-clock strobe. The strobe carries a 17-bit address and the levels of the active-low chip-select and the active-low write strobe. Software asks for a nonvolatile operation by issuing read accesses in a hidden order. The first five reads must hit a fixed set of key addresses in a fixed order. The sixth read names the operation. When the block sees a complete and correct run, it raises a one-cycle pulse on one of four command outputs: commit to nonvolatile storage, reload from nonvolatile storage, block automatic commit, or allow automatic commit again.

The block also holds the "automatic commit blocked" flag. The two blocking commands set and clear it. The memory array, power sensing and the timing of the transfers are handled elsewhere.

Top module: `cseq_detector`

## Requirements
- R1: After reset the match state is idle, `autocommit_blocked` is 0, and all four command outputs are 0.
- R2: A command is recognised only after five counted reads at these 16-bit addresses, in this order: 0x4E38, 0xB1C7, 0x83E0, 0x7C1F, 0x703F. The sixth counted read then selects the command. The pulse is high during the clock cycle that follows the edge sampling the sixth strobe.
- R3: The sixth address maps to a command as follows: 0x8FC0 gives `cmd_commit`, 0x4C63 gives `cmd_reload`, 0x8B45 gives `cmd_block_on`, and 0x4B46 gives `cmd_block_off`.
- R4: Address bit 16 takes no part in any comparison.
- R5: A counted access with `bus_we_n` = 0 returns the match state to idle and issues no command.
- R6: A counted read that does not match the next expected address returns the match state to idle. If that address is 0x4E38, it is instead counted as the first step of a new run. This also applies to an unrecognised sixth address.
- R7: Strobes with `bus_ce_n` = 1 are not counted and leave the match state unchanged. Cycles without a strobe also change nothing.
- R8: `cmd_block_on` sets `autocommit_blocked` in the same edge. `cmd_block_off` clears it in the same edge. Nothing else changes it.
- R9: Each command pulse lasts exactly one cycle, and at most one command output is high at a time.
- R10: After a command has been issued the match state is idle, so a new command needs a full new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_strobe | input | 1 | One-cycle marker of a completed access |
| bus_addr | input | 17 | Address of the access |
| bus_ce_n | input | 1 | Chip select level, active low |
| bus_we_n | input | 1 | Write strobe level, active low (1 = read) |
| cmd_commit | output | 1 | Pulse: commit to nonvolatile storage |
| cmd_reload | output | 1 | Pulse: reload from nonvolatile storage |
| cmd_block_on | output | 1 | Pulse: block automatic commit |
| cmd_block_off | output | 1 | Pulse: allow automatic commit |
| autocommit_blocked | output | 1 | Automatic-commit blocked flag |

## Verification
The clean run is tried with every one of the four command codes, both with bit 16 clear and with bit 16 set. These runs separate the command decoding from the address masking.

The disturbed runs then place a fault at each of the six positions in turn. The faults are a wrong address, a write, an uncounted strobe with chip select high, and an early restart key. These runs show that an abort really clears the state, that the restart key re-arms at step one, and that uncounted strobes are transparent.

Idle gaps between strobes and a follow-up clean run after each disturbance confirm that the state recovers. The same runs show that the blocked flag tracks only its two commands.

// File: rtl/cseq_pkg.sv
package cseq_pkg;

  localparam int KEY_W    = 16;
  localparam int NUM_KEYS = 5;

  typedef enum logic [2:0] {
    CMD_NONE      = 3'd0,
    CMD_COMMIT    = 3'd1,
    CMD_RELOAD    = 3'd2,
    CMD_BLOCK_ON  = 3'd3,
    CMD_BLOCK_OFF = 3'd4
  } cmd_e;

  // Key address expected at a given step of the unlock run.
  function automatic logic [KEY_W-1:0] key_at(input int idx);
    case (idx)
      0:       key_at = 16'h4E38;
      1:       key_at = 16'hB1C7;
      2:       key_at = 16'h83E0;
      3:       key_at = 16'h7C1F;
      4:       key_at = 16'h703F;
      default: key_at = '0;
    endcase
  endfunction

  // Command named by the final address of a run.
  function automatic cmd_e cmd_of(input logic [KEY_W-1:0] a);
    case (a)
      16'h8FC0: cmd_of = CMD_COMMIT;
      16'h4C63: cmd_of = CMD_RELOAD;
      16'h8B45: cmd_of = CMD_BLOCK_ON;
      16'h4B46: cmd_of = CMD_BLOCK_OFF;
      default:  cmd_of = CMD_NONE;
    endcase
  endfunction

endpackage

// File: rtl/cseq_key_compare.sv
module cseq_key_compare
  import cseq_pkg::*;
#(
  parameter int CMP_W  = KEY_W,
  parameter int STEP_W = $clog2(NUM_KEYS + 1)
) (
  input  logic [STEP_W-1:0] step,
  input  logic [CMP_W-1:0]  addr_low,
  output logic              advance,
  output logic              restart,
  output cmd_e              cmd_sel
);

  logic [NUM_KEYS-1:0] key_hit;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_KEYS; gi++) begin : g_key
      assign key_hit[gi] = (addr_low == key_at(gi));
    end
  endgenerate

  always_comb begin
    advance = 1'b0;
    for (int i = 0; i < NUM_KEYS; i++) begin
      if (step == STEP_W'(i) && key_hit[i]) advance = 1'b1;
    end
  end

  assign restart = key_hit[0];
  assign cmd_sel = (step == STEP_W'(NUM_KEYS)) ? cmd_of(addr_low) : CMD_NONE;

endmodule

// File: rtl/cseq_tracker.sv
module cseq_tracker
  import cseq_pkg::*;
#(
  parameter int STEP_W = $clog2(NUM_KEYS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              advance,
  input  logic              restart,
  input  cmd_e              cmd_sel,
  output logic [STEP_W-1:0] step,
  output logic              fire
);

  localparam logic [STEP_W-1:0] LAST = STEP_W'(NUM_KEYS);

  logic              counted;
  logic              is_write;
  logic [STEP_W-1:0] step_nxt;

  assign counted  = strobe && !ce_n;
  assign is_write = counted && !we_n;
  assign fire     = counted && we_n && (step == LAST) && (cmd_sel != CMD_NONE);

  always_comb begin
    step_nxt = step;
    if (counted) begin
      if (!we_n)        step_nxt = '0;
      else if (fire)    step_nxt = '0;
      else if (advance) step_nxt = step + 1'b1;
      else if (restart) step_nxt = STEP_W'(1);
      else              step_nxt = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) step <= '0;
    else        step <= step_nxt;
  end

  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    is_write |=> (step == '0)); // R5
  AST_UNCOUNTED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !counted |=> $stable(step)); // R7
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    step <= LAST); // R2
  AST_FIRE_RETURNS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (step == '0)); // R10

endmodule

// File: rtl/cseq_cmd_out.sv
module cseq_cmd_out
  import cseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  cmd_e cmd_sel,
  output logic cmd_commit,
  output logic cmd_reload,
  output logic cmd_block_on,
  output logic cmd_block_off,
  output logic blocked
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_commit    <= 1'b0;
      cmd_reload    <= 1'b0;
      cmd_block_on  <= 1'b0;
      cmd_block_off <= 1'b0;
      blocked       <= 1'b0;
    end else begin
      cmd_commit    <= fire && (cmd_sel == CMD_COMMIT);
      cmd_reload    <= fire && (cmd_sel == CMD_RELOAD);
      cmd_block_on  <= fire && (cmd_sel == CMD_BLOCK_ON);
      cmd_block_off <= fire && (cmd_sel == CMD_BLOCK_OFF);
      if (fire && cmd_sel == CMD_BLOCK_ON)       blocked <= 1'b1;
      else if (fire && cmd_sel == CMD_BLOCK_OFF) blocked <= 1'b0;
    end
  end

  AST_ONE_COMMAND: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_commit, cmd_reload, cmd_block_on, cmd_block_off})); // R9
  AST_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_commit || cmd_reload || cmd_block_on || cmd_block_off) |=>
    !(cmd_commit || cmd_reload || cmd_block_on || cmd_block_off)); // R9
  AST_BLOCK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_block_on |-> blocked); // R8
  AST_BLOCK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_block_off |-> !blocked); // R8
  AST_BLOCK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(blocked)); // R8

endmodule

// File: rtl/cseq_detector.sv
module cseq_detector
  import cseq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_strobe,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_ce_n,
  input  logic              bus_we_n,
  output logic              cmd_commit,
  output logic              cmd_reload,
  output logic              cmd_block_on,
  output logic              cmd_block_off,
  output logic              autocommit_blocked
);

  localparam int CMP_W  = KEY_W;
  localparam int STEP_W = $clog2(NUM_KEYS + 1);

  logic [CMP_W-1:0]  addr_low;
  logic [STEP_W-1:0] step;
  logic              advance;
  logic              restart;
  logic              fire;
  cmd_e              cmd_sel;

  assign addr_low = bus_addr[CMP_W-1:0];

  cseq_key_compare #(.CMP_W(CMP_W), .STEP_W(STEP_W)) u_cmp (
    .step     (step),
    .addr_low (addr_low),
    .advance  (advance),
    .restart  (restart),
    .cmd_sel  (cmd_sel)
  );

  cseq_tracker #(.STEP_W(STEP_W)) u_trk (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (bus_strobe),
    .ce_n    (bus_ce_n),
    .we_n    (bus_we_n),
    .advance (advance),
    .restart (restart),
    .cmd_sel (cmd_sel),
    .step    (step),
    .fire    (fire)
  );

  cseq_cmd_out u_out (
    .clk           (clk),
    .rst_n         (rst_n),
    .fire          (fire),
    .cmd_sel       (cmd_sel),
    .cmd_commit    (cmd_commit),
    .cmd_reload    (cmd_reload),
    .cmd_block_on  (cmd_block_on),
    .cmd_block_off (cmd_block_off),
    .blocked       (autocommit_blocked)
  );

  AST_PULSE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (bus_we_n && !bus_ce_n && bus_strobe)); // R5
  AST_PULSE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_commit || cmd_reload || cmd_block_on || cmd_block_off) |->
    ($past(step) == STEP_W'(NUM_KEYS))); // R2

endmodule

// File: tb/test_cseq_detector.sv
module test_cseq_detector;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_strobe = 1'b0;
  logic [16:0] bus_addr = '0;
  logic        bus_ce_n = 1'b1;
  logic        bus_we_n = 1'b1;
  logic        cmd_commit, cmd_reload, cmd_block_on, cmd_block_off, autocommit_blocked;

  int checks = 0;
  int errors = 0;
  int mstep = 0;
  logic mblk = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cseq_detector i_cseq_detector (
    .clk(clk), .rst_n(rst_n), .bus_strobe(bus_strobe), .bus_addr(bus_addr),
    .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n), .cmd_commit(cmd_commit),
    .cmd_reload(cmd_reload), .cmd_block_on(cmd_block_on),
    .cmd_block_off(cmd_block_off), .autocommit_blocked(autocommit_blocked));

  function automatic logic [15:0] key(input int i);
    logic [15:0] k [5] = '{16'h4E38, 16'hB1C7, 16'h83E0, 16'h7C1F, 16'h703F};
    return k[i];
  endfunction

  function automatic logic [15:0] cmd_addr(input int c);
    logic [15:0] t [4] = '{16'h8FC0, 16'h4C63, 16'h8B45, 16'h4B46};
    return t[c];
  endfunction

  task automatic check(input string tag, input logic [4:0] exp);
    logic [4:0] act;
    act = {cmd_commit, cmd_reload, cmd_block_on, cmd_block_off, autocommit_blocked};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outputs %b expected %b", tag, act, exp);
    end
  endtask

  // One bus access followed by a check of the cycle after it, then a
  // quiet cycle in which all pulses must be low again.
  task automatic access(input logic [16:0] a, input logic ce_n,
                        input logic we_n, input string tag, input int gap);
    logic [4:0] exp;
    int cmd;
    exp = '0;
    cmd = -1;
    if (!ce_n) begin
      if (!we_n) mstep = 0;
      else if (mstep == 5) begin
        for (int c = 0; c < 4; c++) if (a[15:0] == cmd_addr(c)) cmd = c;
        if (cmd >= 0) mstep = 0;
        else mstep = (a[15:0] == key(0)) ? 1 : 0;
      end else if (a[15:0] == key(mstep)) mstep++;
      else mstep = (a[15:0] == key(0)) ? 1 : 0;
    end
    if (cmd == 2) mblk = 1'b1;
    if (cmd == 3) mblk = 1'b0;
    if (cmd >= 0) exp[4-cmd] = 1'b1;
    exp[0] = mblk;
    @(negedge clk);
    bus_strobe = 1'b1; bus_addr = a; bus_ce_n = ce_n; bus_we_n = we_n;
    @(negedge clk);
    bus_strobe = 1'b0; bus_addr = ~a; bus_ce_n = ~ce_n; bus_we_n = ~we_n;
    check(tag, exp);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      check("R9 pulse ends / R10 idle gap", {4'b0000, mblk});
    end
  endtask

  task automatic run(input int c, input logic b16, input string tag);
    for (int i = 0; i < 5; i++) access({b16, key(i)}, 1'b0, 1'b1, tag, i % 2);
    access({b16, cmd_addr(c)}, 1'b0, 1'b1, tag, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", 5'b00000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 5'b00000);

    // R2 R3 R8: every command, bit 16 clear
    for (int c = 0; c < 4; c++) run(c, 1'b0, "R3 command decode");
    // R4: bit 16 set on every address
    for (int c = 0; c < 4; c++) run(c, 1'b1, "R4 bit16 ignored");
    run(2, 1'b0, "R8 block set");

    // Fault at each position, then a clean run to confirm recovery.
    for (int pos = 0; pos < 6; pos++) begin
      for (int mode = 0; mode < 5; mode++) begin
        for (int i = 0; i < 6; i++) begin
          logic [15:0] a;
          a = (i < 5) ? key(i) : cmd_addr((pos + mode) % 4);
          if (i == pos) begin
            case (mode)
              0: access({1'b0, a ^ 16'h0100}, 1'b0, 1'b1, "R6 wrong address", 0);
              1: access({1'b0, a}, 1'b0, 1'b0, "R5 write aborts", 0);
              2: begin
                access({1'b0, 16'h1234}, 1'b1, 1'b1, "R7 ce high ignored", 0);
                access({1'b0, key(0)}, 1'b1, 1'b0, "R7 ce high write ignored", 0);
                access({1'b0, a}, 1'b0, 1'b1, "R7 run continues", 0);
              end
              3: access({1'b0, key(0)}, 1'b0, 1'b1, "R6 restart key", 0);
              default: access({1'b1, 16'hFFFF}, 1'b0, 1'b1, "R6 unmatched", 0);
            endcase
          end else begin
            access({1'b0, a}, 1'b0, 1'b1, "R2 sequence step", 0);
          end
        end
        run((pos + mode + 1) % 4, 1'b0, "R10 recovery run");
      end
    end

    // R10: a repeated sixth address without a new run issues nothing.
    run(0, 1'b0, "R10 first command");
    access({1'b0, cmd_addr(0)}, 1'b0, 1'b1, "R10 no second command", 1);
    run(3, 1'b0, "R8 block clear");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule